// File: doc/BRIEF.md
# Dual-Clock Configuration Update Synchronizer

This block moves a configuration word from a bus clock domain into an unrelated serial clock domain. A bus-side write latches the word into a holding register and toggles a request bit. The serial side runs that bit through a two-flop synchronizer and detects the toggle. It then captures the held word onto its configuration output and holds the serial state machines in reset for a fixed number of serial cycles. When that reset ends it toggles an acknowledge bit, which returns through a second two-flop synchronizer. The holding register changes only while no update is in flight, so the multi-bit word is never sampled while it moves.

A bus-side ready flag falls after every write and rises once the acknowledge is back. Software must not start serial traffic until ready is high. A write that arrives while an update is in flight is parked. A later write replaces a parked word, so only the newest one is sent once the acknowledge returns. With the default parameters, the whole round trip finishes within eight cycles of the slower clock. This holds as long as the serial clock is at most four times the bus clock frequency.

Top module: `cfg_sync`

## Requirements
- R1: While rst_ni is low and after it is released with no write, ready_o is 1, cfg_o equals RESET_CFG (all zeros by default) and sm_rst_o is 0.
- R2: A write (wr_en_i high at a bus clock edge) makes ready_o read 0 after that edge. ready_o never rises on the bus cycle that directly follows a write.
- R3: cfg_o changes only at the serial edge where sm_rst_o rises, and the value it takes is the bus-side word of that update. Without writes, cfg_o holds its value and no reset pulse occurs.
- R4: Each update drives sm_rst_o high for exactly RST_CYC consecutive serial cycles (default 2).
- R5: For a write made while ready_o is high, ready_o returns to 1 within eight periods of the slower clock, measured from the write edge. By that time cfg_o carries the written word.
- R6: Writes made while ready_o is low are parked, and each later one replaces the parked word. After a burst of writes, the last word written lands on cfg_o and ready_o returns to 1. A write on the same bus cycle that a parked word would launch is sent in its place, and the parked word is dropped.
- R7: Landed words appear in write order. Each one is a word that was written, and none is older than the one landed before it.
- R8: Every update makes one reset pulse, including a write that repeats the current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | Bus clock |
| sclk_i | input | 1 | Serial clock, asynchronous to bclk_i |
| rst_ni | input | 1 | Active-low asynchronous reset, released per domain through a synchronizer |
| wr_en_i | input | 1 | Bus-side configuration write strobe |
| wr_data_i | input | W | Configuration word to write |
| ready_o | output | 1 | Bus domain: no update in flight or parked, so traffic may start |
| cfg_o | output | W | Serial domain: stable configuration word |
| sm_rst_o | output | 1 | Serial domain: reset for the serial state machines, high RST_CYC cycles per update |

## Verification
The collision that matters is a bus write on the same cycle that the returning acknowledge would launch a parked word. The design must send the new word and drop the parked one. The bench provokes this with bursts of back-to-back writes at several clock ratios, so the write strobe overlaps the acknowledge arrival at varying phases. A scoreboard judges the result. It skips only words that a newer write dropped, it requires the last word of each burst to land, and it checks that ready_o returns with that word on cfg_o.

// File: rtl/cfg_sync_pkg.sv
`timescale 1ns/1ps
package cfg_sync_pkg;
  typedef enum logic [0:0] {
    DST_IDLE = 1'b0,
    DST_RST  = 1'b1
  } dst_state_e;
endpackage

// File: rtl/cfg_sync_rst.sv
`timescale 1ns/1ps
// Async assert, synchronous release.
module cfg_sync_rst #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] rs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= '0;
    else         rs_q <= {rs_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = rs_q[STAGES-1];
endmodule

// File: rtl/cfg_sync_bit.sv
`timescale 1ns/1ps
module cfg_sync_bit #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sq <= '0;
    else         sq <= {sq[STAGES-2:0], d_i};
  end

  assign q_o = sq[STAGES-1];
endmodule

// File: rtl/cfg_sync_src.sv
`timescale 1ns/1ps
// Bus side: hold register, request toggle, one-deep park slot (newest wins).
module cfg_sync_src #(
  parameter int           W         = 16,
  parameter logic [W-1:0] RESET_CFG = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         ack_tgl_i,
  output logic         req_tgl_o,
  output logic [W-1:0] hold_o,
  output logic         ready_o
);
  logic         req_q;
  logic         pend_q;
  logic [W-1:0] hold_q;
  logic [W-1:0] pend_data_q;
  logic         idle;

  assign idle = (req_q == ack_tgl_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q       <= 1'b0;
      pend_q      <= 1'b0;
      hold_q      <= RESET_CFG;
      pend_data_q <= '0;
    end else if (wr_en_i && idle) begin
      // fresh write beats any parked word
      hold_q <= wr_data_i;
      req_q  <= ~req_q;
      pend_q <= 1'b0;
    end else if (wr_en_i) begin
      pend_q      <= 1'b1;
      pend_data_q <= wr_data_i;
    end else if (idle && pend_q) begin
      hold_q <= pend_data_q;
      req_q  <= ~req_q;
      pend_q <= 1'b0;
    end
  end

  assign req_tgl_o = req_q;
  assign hold_o    = hold_q;
  assign ready_o   = idle & ~pend_q;
endmodule

// File: rtl/cfg_sync_dst.sv
`timescale 1ns/1ps
// Serial side: capture on request edge, hold reset RST_CYC cycles, then ack.
module cfg_sync_dst
  import cfg_sync_pkg::*;
#(
  parameter int           W         = 16,
  parameter logic [W-1:0] RESET_CFG = '0,
  parameter int           RST_CYC   = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_tgl_i,
  input  logic [W-1:0] hold_i,
  output logic [W-1:0] cfg_o,
  output logic         sm_rst_o,
  output logic         ack_tgl_o
);
  localparam int CNT_W = $clog2(RST_CYC + 1);

  dst_state_e   state_q;
  logic [CNT_W-1:0] cnt_q;
  logic         req_d_q;
  logic         ack_q;
  logic [W-1:0] cfg_q;
  logic         req_edge;

  assign req_edge = req_tgl_i ^ req_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= DST_IDLE;
      cnt_q   <= '0;
      req_d_q <= 1'b0;
      ack_q   <= 1'b0;
      cfg_q   <= RESET_CFG;
    end else begin
      req_d_q <= req_tgl_i;
      case (state_q)
        DST_IDLE: begin
          if (req_edge) begin
            cfg_q   <= hold_i;  // hold_i is stable while a request is open
            cnt_q   <= CNT_W'(RST_CYC - 1);
            state_q <= DST_RST;
          end
        end
        DST_RST: begin
          if (cnt_q == '0) begin
            state_q <= DST_IDLE;
            ack_q   <= ~ack_q;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= DST_IDLE;
      endcase
    end
  end

  assign cfg_o     = cfg_q;
  assign sm_rst_o  = (state_q == DST_RST);
  assign ack_tgl_o = ack_q;
endmodule

// File: rtl/cfg_sync.sv
`timescale 1ns/1ps
module cfg_sync #(
  parameter int           W           = 16,
  parameter logic [W-1:0] RESET_CFG   = '0,
  parameter int           RST_CYC     = 2,
  parameter int           SYNC_STAGES = 2
) (
  input  logic         bclk_i,
  input  logic         sclk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic         ready_o,
  output logic [W-1:0] cfg_o,
  output logic         sm_rst_o
);
  logic         b_rst_n;
  logic         s_rst_n;
  logic         req_tgl;
  logic         req_tgl_s;
  logic         ack_tgl;
  logic         ack_tgl_b;
  logic [W-1:0] hold_w;

  cfg_sync_rst #(.STAGES(SYNC_STAGES)) u_brst (
    .clk_i (bclk_i), .rst_ni(rst_ni), .rst_no(b_rst_n)
  );

  cfg_sync_rst #(.STAGES(SYNC_STAGES)) u_srst (
    .clk_i (sclk_i), .rst_ni(rst_ni), .rst_no(s_rst_n)
  );

  cfg_sync_src #(.W(W), .RESET_CFG(RESET_CFG)) u_src (
    .clk_i     (bclk_i),
    .rst_ni    (b_rst_n),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .ack_tgl_i (ack_tgl_b),
    .req_tgl_o (req_tgl),
    .hold_o    (hold_w),
    .ready_o   (ready_o)
  );

  cfg_sync_bit #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk_i (sclk_i), .rst_ni(s_rst_n), .d_i(req_tgl), .q_o(req_tgl_s)
  );

  cfg_sync_dst #(.W(W), .RESET_CFG(RESET_CFG), .RST_CYC(RST_CYC)) u_dst (
    .clk_i     (sclk_i),
    .rst_ni    (s_rst_n),
    .req_tgl_i (req_tgl_s),
    .hold_i    (hold_w),
    .cfg_o     (cfg_o),
    .sm_rst_o  (sm_rst_o),
    .ack_tgl_o (ack_tgl)
  );

  cfg_sync_bit #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk_i (bclk_i), .rst_ni(b_rst_n), .d_i(ack_tgl), .q_o(ack_tgl_b)
  );
endmodule

// File: rtl/cfg_sync_chk.sv
`timescale 1ns/1ps
module cfg_sync_chk #(
  parameter int W       = 16,
  parameter int RST_CYC = 2
) (
  input logic         bclk_i,
  input logic         sclk_i,
  input logic         b_rst_ni,
  input logic         s_rst_ni,
  input logic         wr_en_i,
  input logic         ready_o,
  input logic [W-1:0] cfg_o,
  input logic         sm_rst_o,
  input logic [W-1:0] hold_i
);
  logic [7:0] run_q;

  always_ff @(posedge sclk_i or negedge s_rst_ni) begin
    if (!s_rst_ni)     run_q <= '0;
    else if (sm_rst_o) run_q <= run_q + 8'd1;
    else               run_q <= '0;
  end

  // R2
  wr_ready_drop_chk: assert property (@(posedge bclk_i) disable iff (!b_rst_ni)
    wr_en_i |=> !ready_o);

  // R2
  ready_rise_chk: assert property (@(posedge bclk_i) disable iff (!b_rst_ni)
    $rose(ready_o) |-> !$past(wr_en_i));

  // R3
  cfg_stable_chk: assert property (@(posedge sclk_i) disable iff (!s_rst_ni)
    !$rose(sm_rst_o) |-> $stable(cfg_o));

  // R3
  cfg_capture_chk: assert property (@(posedge sclk_i) disable iff (!s_rst_ni)
    $rose(sm_rst_o) |-> (cfg_o == hold_i));

  // R4
  rst_len_chk: assert property (@(posedge sclk_i) disable iff (!s_rst_ni)
    $fell(sm_rst_o) |-> (run_q == 8'(RST_CYC)));
endmodule

bind cfg_sync cfg_sync_chk #(.W(W), .RST_CYC(RST_CYC)) u_chk (
  .bclk_i   (bclk_i),
  .sclk_i   (sclk_i),
  .b_rst_ni (b_rst_n),
  .s_rst_ni (s_rst_n),
  .wr_en_i  (wr_en_i),
  .ready_o  (ready_o),
  .cfg_o    (cfg_o),
  .sm_rst_o (sm_rst_o),
  .hold_i   (hold_w)
);

// File: tb/cfg_sync_tb_top.sv
`timescale 1ns/1ps
module cfg_sync_tb_top;
  localparam int W       = 16;
  localparam int RST_CYC = 2;
  localparam real BPER   = 20.0;

  logic         bclk = 1'b0;
  logic         sclk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         ready;
  logic [W-1:0] cfg;
  logic         sm_rst;

  real sper = 20.0;
  int  checks = 0;
  int  errors = 0;
  int  landed = 0;
  int  dropped = 0;
  int  run = 0;
  bit  prev_rst = 1'b0;
  logic [W-1:0] exp_q[$];

  cfg_sync #(.W(W), .RST_CYC(RST_CYC)) dut_i (
    .bclk_i(bclk), .sclk_i(sclk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_data_i(wr_data),
    .ready_o(ready), .cfg_o(cfg), .sm_rst_o(sm_rst)
  );

  always #(BPER/2.0) bclk = ~bclk;
  initial forever #(sper/2.0) sclk = ~sclk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: pop expected words as updates land on the serial side.
  always @(negedge sclk) begin
    if (sm_rst === 1'b1 && !prev_rst) begin
      landed++;
      while (exp_q.size() > 0 && exp_q[0] != cfg) begin
        void'(exp_q.pop_front());
        dropped++;
      end
      if (exp_q.size() == 0) chk(1'b0, "R7 landed word not in order", cfg, 0);
      else chk(exp_q.pop_front() == cfg, "R7 landed word", cfg, cfg);
    end
    if (sm_rst === 1'b1) run++;
    else if (prev_rst) begin
      chk(run == RST_CYC, "R4 reset pulse length", run, RST_CYC);
      run = 0;
    end
    prev_rst = (sm_rst === 1'b1);
  end

  task automatic drive(input logic [W-1:0] d);
    @(negedge bclk);
    wr_en   = 1'b1;
    wr_data = d;
    exp_q.push_back(d);
  endtask

  task automatic wait_ready(input int lim);
    for (int n = 0; n < lim && ready !== 1'b1; n++) @(negedge bclk);
  endtask

  task automatic single_update(input logic [W-1:0] d);
    real t_wr, slow;
    int  l0, dt;
    slow = (sper > BPER) ? sper : BPER;
    l0 = landed;
    drive(d);
    t_wr = $realtime + BPER/2.0;
    @(negedge bclk);
    wr_en = 1'b0;
    chk(ready === 1'b0, "R2 ready low after write", ready, 0);
    wait_ready(60);
    dt = $rtoi($realtime - BPER/2.0 - t_wr);
    chk(ready === 1'b1 && dt <= $rtoi(8.0*slow), "R5 settle within 8 slow cycles", dt, $rtoi(8.0*slow));
    chk(cfg == d, "R5 word on cfg_o at ready", cfg, d);
    chk(landed - l0 == 1, "R8 one reset per update", landed - l0, 1);
  endtask

  task automatic burst(input int n, input logic [W-1:0] base);
    int l0;
    logic [W-1:0] last;
    l0 = landed;
    last = base;
    for (int i = 0; i < n; i++) begin
      last = base + W'(i * 7);
      drive(last);
    end
    @(negedge bclk);
    wr_en = 1'b0;
    chk(ready === 1'b0, "R6 ready low during burst", ready, 0);
    wait_ready(120);
    repeat (2) @(negedge bclk);
    chk(ready === 1'b1, "R6 ready back after burst", ready, 1);
    chk(cfg == last, "R6 last word lands", cfg, last);
    chk(exp_q.size() == 0, "R6 newest word consumed", exp_q.size(), 0);
    chk(landed - l0 >= 2 && landed - l0 <= n, "R6 parked words dropped", landed - l0, 2);
  endtask

  initial begin
    repeat (150000) @(posedge bclk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    real periods[5] = '{20.0, 13.0, 6.0, 47.0, 80.0};
    int l0;
    repeat (4) @(negedge bclk);
    chk(cfg == '0 && sm_rst === 1'b0, "R1 outputs in reset", cfg, 0);
    rst_n = 1'b1;
    repeat (8) @(negedge bclk);
    chk(ready === 1'b1, "R1 ready after reset", ready, 1);
    chk(cfg == '0, "R1 cfg reset value", cfg, 0);
    chk(sm_rst === 1'b0, "R1 no reset pulse", sm_rst, 0);

    foreach (periods[k]) begin
      sper = periods[k];
      repeat (6) @(negedge bclk);
      single_update(W'(16'h0001 << k) ^ 16'h3C00);
      single_update(~(W'(16'h0001 << k)));
      single_update(16'hBEEF);
      single_update(16'hBEEF);
    end

    sper = 6.0;  repeat (6) @(negedge bclk); burst(5, 16'h1100);
    sper = 47.0; repeat (6) @(negedge bclk); burst(6, 16'h2200);
    sper = 13.0; repeat (6) @(negedge bclk); burst(30, 16'h4400);
    sper = 20.0; repeat (6) @(negedge bclk); burst(17, 16'h8800);

    // R3: idle, no pulses, cfg held
    l0 = landed;
    repeat (60) @(negedge bclk);
    chk(landed == l0, "R3 no update without write", landed - l0, 0);
    chk(cfg == 16'h8800 + W'(16*7), "R3 cfg held while idle", cfg, 16'h8800 + W'(16*7));
    chk(dropped > 0, "R6 some parked words were dropped", dropped, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule